// File: doc/BRIEF.md
# Processor Reset and Soft-Restart Sequencer

This block brings the architectural state of a small processor core to its defined power-on values. It distinguishes two entry paths. The first is a full hardware reset, which clears everything and can run a built-in self-test. The second is a lighter soft restart (INIT), which reloads the start-up register values and flushes address-translation and branch-prediction state. The soft restart leaves caches, model-specific registers and floating-point state alone. The caches, the TLB and the other storage are not modelled. The block only issues one-cycle invalidate strobes toward them.

The self-test is requested through a strap pin and runs for a parameterised number of cycles. Its result code lands in the accumulator output. A test-only fault input forces a failing result. A ready flag tells the rest of the core when the start-up state is settled. All pins are plain control and status wires with no data stream, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `rst_init_seq`

## Requirements
- R1: Whenever `ready_o` is high after a hardware reset or a soft restart, `flags_o` reads 32'h0000_0002, `ip_o` reads 32'h0000_FFF0 and `ctrl_o` reads 32'h6000_0010.
- R2: After `rst_n` is released, the first rising clock edge that sees `rst_n` and `init_n` both high raises all five invalidate strobes for exactly the following cycle. The strobes form the vector {tlb, btb, cache, msr, fpu} = 5'b11111.
- R3: After `init_n` is released, the first rising edge raises only the TLB and BTB strobes for one cycle ({tlb, btb, cache, msr, fpu} = 5'b11000). The cache, MSR and FPU strobes stay low.
- R4: The strap `bist_req_i` is read at that release edge of a hardware reset. When it is high, the self-test occupies BIST_CYCLES cycles. The accumulator is written at release edge + BIST_CYCLES, and a passing test writes 32'h0.
- R5: If `fault_inj_i` is high in any cycle of the self-test, the accumulator is written with 32'h0000_0001 at the end of the test.
- R6: Without the strap, a hardware reset leaves the accumulator at 32'h0 and no self-test runs. `ready_o` is high two edges after the release edge is counted as the first.
- R7: A soft restart never starts the self-test and never changes the accumulator, even when it cuts a running self-test short.
- R8: `ready_o` is low while `rst_n` or `init_n` is low, during the strobe cycle and during the self-test. It rises one edge after the start-up values are loaded and any self-test result is written.
- R9: When a hardware reset and a soft restart overlap, the hardware reset wins. If `init_n` is still low when `rst_n` rises, the block waits, and on release of `init_n` it performs the full hardware reset sequence (R2, R4).
- R10: Every invalidate strobe is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assertion |
| init_n | input | 1 | Soft restart request, active low |
| bist_req_i | input | 1 | Self-test request strap |
| fault_inj_i | input | 1 | Test-only fault injection during self-test |
| flags_o | output | 32 | Flags register value |
| ip_o | output | 32 | Instruction pointer value |
| ctrl_o | output | 32 | Control register value |
| acc_o | output | 32 | Accumulator, carries self-test result |
| inv_tlb_o | output | 1 | TLB invalidate strobe |
| inv_btb_o | output | 1 | Branch target buffer invalidate strobe |
| inv_cache_o | output | 1 | Cache invalidate strobe |
| inv_msr_o | output | 1 | Model-specific register reset strobe |
| inv_fpu_o | output | 1 | Floating-point state reset strobe |
| ready_o | output | 1 | Start-up state settled |

## Verification
All results are counted from the release edge, which is the first rising edge that sees the request pins high. The strobes are due one edge after release. Without a self-test, ready and the register values are due two edges after release. With a self-test, the accumulator is due BIST_CYCLES edges after release and ready one edge later. The driver turns each stimulus into expected items stamped with the edge count at which they fall due. The monitor compares them half a clock after that edge, so a result that arrives one cycle early or late is reported against its requirement.

// File: rtl/rst_init_pkg.sv
package rst_init_pkg;
  localparam int WORD_W = 32;

  localparam logic [WORD_W-1:0] FLAGS_START = 32'h0000_0002;
  localparam logic [WORD_W-1:0] IP_START    = 32'h0000_FFF0;
  localparam logic [WORD_W-1:0] CTRL_START  = 32'h6000_0010;
  localparam logic [WORD_W-1:0] ACC_PASS    = 32'h0000_0000;
  localparam logic [WORD_W-1:0] ACC_FAULT   = 32'h0000_0001;

  typedef enum logic [2:0] {
    ST_HWHOLD,
    ST_SOFTHOLD,
    ST_SELFTEST,
    ST_LOADED,
    ST_READY
  } seq_state_e;

  typedef struct packed {
    logic tlb;
    logic btb;
    logic cache;
    logic msr;
    logic fpu;
  } inv_vec_t;

  localparam inv_vec_t INV_FULL = '{tlb: 1'b1, btb: 1'b1, cache: 1'b1, msr: 1'b1, fpu: 1'b1};
  localparam inv_vec_t INV_SOFT = '{tlb: 1'b1, btb: 1'b1, cache: 1'b0, msr: 1'b0, fpu: 1'b0};
endpackage

// File: rtl/rsi_selftest.sv
module rsi_selftest
  import rst_init_pkg::*;
#(
  parameter int BIST_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic fault_i,
  output logic done_o,
  output logic fail_o
);
  localparam int CNT_W = (BIST_CYCLES < 2) ? 1 : $clog2(BIST_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fault_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_seen_q <= 1'b0;
    end else if (!run_i) begin
      fault_seen_q <= 1'b0;
    end else if (fault_i) begin
      fault_seen_q <= 1'b1;
    end
  end

  assign done_o = run_i && (cnt_q == LAST);
  assign fail_o = fault_seen_q || fault_i;
endmodule

// File: rtl/rsi_arch_regs.sv
module rsi_arch_regs
  import rst_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              result_we_i,
  input  logic              result_fail_i,
  output logic [WORD_W-1:0] flags_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] acc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_o <= FLAGS_START;
      ip_o    <= IP_START;
      ctrl_o  <= CTRL_START;
    end else if (load_i) begin
      flags_o <= FLAGS_START;
      ip_o    <= IP_START;
      ctrl_o  <= CTRL_START;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o <= ACC_PASS;
    end else if (result_we_i) begin
      acc_o <= result_fail_i ? ACC_FAULT : ACC_PASS;
    end
  end
endmodule

// File: rtl/rsi_seq_fsm.sv
module rsi_seq_fsm
  import rst_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_n,
  input  logic       strap_i,
  input  logic       test_done_i,
  output logic       test_run_o,
  output logic       load_o,
  output inv_vec_t   inv_o,
  output logic       ready_o
);
  seq_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HWHOLD;
      inv_o   <= '0;
      ready_o <= 1'b0;
    end else begin
      inv_o <= '0;
      if (!init_n) begin
        if (state_q != ST_HWHOLD) begin
          state_q <= ST_SOFTHOLD;
        end
        ready_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_HWHOLD: begin
            inv_o   <= INV_FULL;
            state_q <= strap_i ? ST_SELFTEST : ST_LOADED;
          end
          ST_SOFTHOLD: begin
            inv_o   <= INV_SOFT;
            state_q <= ST_LOADED;
          end
          ST_SELFTEST: begin
            if (test_done_i) begin
              state_q <= ST_LOADED;
            end
          end
          ST_LOADED: begin
            state_q <= ST_READY;
            ready_o <= 1'b1;
          end
          ST_READY: begin
            ready_o <= 1'b1;
          end
          default: state_q <= ST_HWHOLD;
        endcase
      end
    end
  end

  assign test_run_o = (state_q == ST_SELFTEST) && init_n;
  assign load_o     = init_n && ((state_q == ST_HWHOLD) || (state_q == ST_SOFTHOLD));
endmodule

// File: rtl/rst_init_seq.sv
module rst_init_seq
  import rst_init_pkg::*;
#(
  parameter int BIST_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_n,
  input  logic        bist_req_i,
  input  logic        fault_inj_i,
  output logic [31:0] flags_o,
  output logic [31:0] ip_o,
  output logic [31:0] ctrl_o,
  output logic [31:0] acc_o,
  output logic        inv_tlb_o,
  output logic        inv_btb_o,
  output logic        inv_cache_o,
  output logic        inv_msr_o,
  output logic        inv_fpu_o,
  output logic        ready_o
);
  logic     test_run;
  logic     test_done;
  logic     test_fail;
  logic     load_now;
  inv_vec_t inv;

  rsi_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_n      (init_n),
    .strap_i     (bist_req_i),
    .test_done_i (test_done),
    .test_run_o  (test_run),
    .load_o      (load_now),
    .inv_o       (inv),
    .ready_o     (ready_o)
  );

  rsi_selftest #(
    .BIST_CYCLES (BIST_CYCLES)
  ) u_selftest (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (test_run),
    .fault_i (fault_inj_i),
    .done_o  (test_done),
    .fail_o  (test_fail)
  );

  rsi_arch_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load_now),
    .result_we_i   (test_done),
    .result_fail_i (test_fail),
    .flags_o       (flags_o),
    .ip_o          (ip_o),
    .ctrl_o        (ctrl_o),
    .acc_o         (acc_o)
  );

  assign inv_tlb_o   = inv.tlb;
  assign inv_btb_o   = inv.btb;
  assign inv_cache_o = inv.cache;
  assign inv_msr_o   = inv.msr;
  assign inv_fpu_o   = inv.fpu;
endmodule

// File: rtl/rsi_chk.sv
module rsi_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        init_n,
  input logic [31:0] flags_o,
  input logic [31:0] ip_o,
  input logic [31:0] ctrl_o,
  input logic [31:0] acc_o,
  input logic        inv_tlb_o,
  input logic        inv_btb_o,
  input logic        inv_cache_o,
  input logic        inv_msr_o,
  input logic        inv_fpu_o,
  input logic        ready_o
);
  // R10
  tlb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_tlb_o |=> !inv_tlb_o);

  // R10
  cache_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_cache_o |=> !inv_cache_o);

  // R2
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_cache_o |-> (inv_tlb_o && inv_btb_o && inv_msr_o && inv_fpu_o));

  // R3
  soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_tlb_o && !inv_cache_o) |-> (inv_btb_o && !inv_msr_o && !inv_fpu_o));

  // R8
  ready_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |=> !ready_o);

  // R8
  ready_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_tlb_o |-> !ready_o);

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && init_n) |=> $stable(acc_o));

  // R1
  start_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (flags_o == 32'h2 && ip_o == 32'hFFF0 && ctrl_o == 32'h6000_0010));

  // R5
  acc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (acc_o <= 32'h1));
endmodule

bind rst_init_seq rsi_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_n      (init_n),
  .flags_o     (flags_o),
  .ip_o        (ip_o),
  .ctrl_o      (ctrl_o),
  .acc_o       (acc_o),
  .inv_tlb_o   (inv_tlb_o),
  .inv_btb_o   (inv_btb_o),
  .inv_cache_o (inv_cache_o),
  .inv_msr_o   (inv_msr_o),
  .inv_fpu_o   (inv_fpu_o),
  .ready_o     (ready_o)
);

// File: tb/tb_rst_init_seq.sv
module tb_rst_init_seq;
  localparam int LEN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_n = 1'b1;
  logic        bist_req_i = 1'b0;
  logic        fault_inj_i = 1'b0;
  logic [31:0] flags_o, ip_o, ctrl_o, acc_o;
  logic        inv_tlb_o, inv_btb_o, inv_cache_o, inv_msr_o, inv_fpu_o, ready_o;

  always #4 clk = ~clk;

  rst_init_seq #(.BIST_CYCLES(LEN)) dut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .bist_req_i(bist_req_i),
    .fault_inj_i(fault_inj_i), .flags_o(flags_o), .ip_o(ip_o), .ctrl_o(ctrl_o),
    .acc_o(acc_o), .inv_tlb_o(inv_tlb_o), .inv_btb_o(inv_btb_o),
    .inv_cache_o(inv_cache_o), .inv_msr_o(inv_msr_o), .inv_fpu_o(inv_fpu_o),
    .ready_o(ready_o)
  );

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   tests = 0;
  int   fails = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return flags_o;
      1: return ip_o;
      2: return ctrl_o;
      3: return acc_o;
      4: return {27'd0, inv_tlb_o, inv_btb_o, inv_cache_o, inv_msr_o, inv_fpu_o};
      default: return {31'd0, ready_o};
    endcase
  endfunction

  // monitor: half a clock after each rising edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic [31:0] got;
      e = q.pop_front();
      got = observe(e.sel);
      tests++;
      if (e.due != cyc || got !== e.val) begin
        fails++;
        $display("FAIL %s sel=%0d cyc=%0d due=%0d got=%h exp=%h", e.req, e.sel, cyc, e.due, got, e.val);
      end
    end
  end

  task automatic push(int k, int sel, logic [31:0] v, string r);
    exp_t e;
    e.due = cyc + k; e.sel = sel; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_regs(int k, string r);
    push(k, 0, 32'h0000_0002, r);
    push(k, 1, 32'h0000_FFF0, r);
    push(k, 2, 32'h6000_0010, r);
  endtask

  initial begin
    tick(1);
    // reset state
    push(0, 5, 32'd0, "R8");
    push(0, 4, 32'd0, "R10");
    push(0, 3, 32'd0, "R6");
    tick(2);

    // R2 R6: hardware reset without self-test
    bist_req_i = 1'b0;
    rst_n = 1'b1;
    push(1, 4, 32'h1F, "R2");
    push(1, 5, 32'd0, "R8");
    push(2, 4, 32'd0, "R10");
    push(2, 5, 32'd1, "R6");
    push(2, 3, 32'd0, "R6");
    expect_regs(2, "R1");
    tick(4);

    // R3: soft restart
    init_n = 1'b0;
    push(1, 5, 32'd0, "R8");
    push(1, 4, 32'd0, "R3");
    tick(3);
    init_n = 1'b1;
    push(1, 4, 32'h18, "R3");
    push(2, 4, 32'd0, "R10");
    push(2, 5, 32'd1, "R8");
    expect_regs(2, "R1");
    tick(4);

    // R4: self-test passes
    rst_n = 1'b0;
    bist_req_i = 1'b1;
    tick(2);
    rst_n = 1'b1;
    push(1, 4, 32'h1F, "R2");
    push(LEN, 5, 32'd0, "R8");
    push(LEN + 1, 3, 32'd0, "R4");
    push(LEN + 1, 5, 32'd0, "R8");
    push(LEN + 2, 5, 32'd1, "R4");
    tick(3);
    fault_inj_i = 1'b0;
    tick(LEN + 2);

    // R5: injected fault mid-test
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    push(LEN + 1, 3, 32'h1, "R5");
    push(LEN + 2, 5, 32'd1, "R5");
    tick(3);
    fault_inj_i = 1'b1;
    tick(1);
    fault_inj_i = 1'b0;
    tick(LEN);

    // R7: soft restart keeps fault code, runs no test
    init_n = 1'b0;
    tick(2);
    init_n = 1'b1;
    push(1, 4, 32'h18, "R7");
    push(2, 5, 32'd1, "R7");
    push(2, 3, 32'h1, "R7");
    tick(4);

    // R9: overlapping requests, hardware reset wins
    rst_n = 1'b0;
    init_n = 1'b0;
    push(0, 3, 32'd0, "R9");
    tick(2);
    rst_n = 1'b1;
    push(2, 5, 32'd0, "R9");
    push(2, 4, 32'd0, "R9");
    tick(3);
    init_n = 1'b1;
    push(1, 4, 32'h1F, "R9");
    push(LEN + 1, 3, 32'd0, "R9");
    push(LEN + 2, 5, 32'd1, "R9");
    tick(LEN + 4);

    // R7: soft restart cuts a failing self-test short
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    fault_inj_i = 1'b1;
    tick(3);
    init_n = 1'b0;
    tick(2);
    fault_inj_i = 1'b0;
    init_n = 1'b1;
    push(1, 4, 32'h18, "R7");
    push(2, 5, 32'd1, "R7");
    push(2, 3, 32'd0, "R7");
    tick(LEN + 4);
    push(0, 3, 32'd0, "R7");
    tick(2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule